// File: doc/BRIEF.md
# Branch Bus-Cycle Sequencer

This block drives the bus activity of a processor core while the core runs a relative branch. When a start strobe arrives, the block captures the branch kind (one-word short form or prefixed long form), whether its condition holds, whether the instruction's first byte sits at an odd address, and whether a second-page prefix byte still has to be consumed. It then emits one cycle-type code per clock until the sequence is finished. The core computes the condition and owns the instruction queue. This block only decides what kind of bus cycle each clock carries, how many clocks the branch takes, and where execution goes next.

Each cycle is one of four kinds: a program word fetch, a free cycle with no bus activity, a fetch at the new target address, or idle when no branch is running. The destination is the address of the next instruction plus the sign-extended offset. It is computed once, when the start is accepted, and is offered with a load strobe on the first target-fetch cycle. A done strobe marks the last cycle. Alignment matters because program memory is read in aligned 16-bit words. A prefix byte or a branch opcode may or may not need its own word access depending on where it falls, and that decides whether some cycles are fetches or free cycles.

Top module: `branch_cycle_seq`

## Requirements
- R1: While reset is high and in the first cycle after it, the cycle code is 00, and the done and load strobes are low.
- R2: Cycle codes are 00 idle, 01 program word fetch, 10 free cycle and 11 fetch at the target. A start sampled high while idle begins a sequence whose first cycle code appears in the clock after that edge and is never 00.
- R3: A short branch whose condition is false takes one cycle, coded 01.
- R4: A short branch whose condition is true takes three cycles, all coded 11. The load strobe is high in the first of them. The target is the next-instruction address plus offset bits [7:0] sign-extended.
- R5: A long branch started with the prefix indication high spends its first cycle on the prefix byte: 01 if the first byte is at an odd address, 10 if it is at an even address.
- R6: The next cycle of a long branch is the optional cycle. It is coded 01 when the branch opcode lies at an even address, and 10 otherwise. The opcode address is the first-byte address plus one when a prefix is present, and the first-byte address itself when it is not.
- R7: After the optional cycle, a long branch whose condition is false runs two cycles coded 01. That makes three cycles not counting the prefix.
- R8: After the optional cycle, a long branch whose condition is true runs three cycles coded 11, for four cycles not counting the prefix. The load strobe is high in the first 11 cycle. The target is the next-instruction address plus the full 16-bit offset.
- R9: The done strobe is high for exactly one clock, in the final cycle of a sequence. The cycle after it is idle (00) unless a new start was accepted.
- R10: A start that is high while a sequence runs, including its done cycle, is ignored. The running sequence and its target are not affected by the inputs presented then.
- R11: For a short branch, the prefix indication has no effect on the cycle codes.
- R12: Target arithmetic wraps modulo 2^ADDR_W.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start_i | input | 1 | Begin a branch sequence; sampled only when idle |
| long_i | input | 1 | 1 = long branch with 16-bit offset, 0 = short branch with 8-bit offset |
| taken_i | input | 1 | Branch condition holds |
| odd_i | input | 1 | First byte of the instruction (the prefix if present) is at an odd address |
| pre_i | input | 1 | Long branch still has its second-page prefix byte to consume |
| next_pc_i | input | ADDR_W | Address of the instruction following the branch |
| offset_i | input | LOFF_W | Relative offset; a short branch uses bits [7:0] |
| cyc_o | output | 2 | Cycle-type code for the current clock |
| load_pc_o | output | 1 | Program counter load strobe |
| target_o | output | ADDR_W | Branch destination, valid while load_pc_o is high |
| done_o | output | 1 | Final cycle of the sequence |

## Verification
The embedded assertions check several rules on every clock. Done is a single pulse followed by idle. The load strobe appears only on a target-fetch cycle. An accepted start always produces a non-idle cycle next. The captured branch context and the target stay frozen while a sequence runs. Only the bench's scenarios show the exact per-cycle code lists, including the alignment-dependent prefix and optional cycles, the sequence lengths and the wrapped target values. The bench sweeps every combination of kind, condition, alignment and prefix against several offsets and addresses, and repeats the sweep while start and the other inputs are toggled during busy cycles.

// File: rtl/bcs_pkg.sv
package bcs_pkg;

    localparam int STEP_W = 3;

    typedef enum logic [1:0] {
        CYC_IDLE  = 2'b00,
        CYC_FETCH = 2'b01,
        CYC_FREE  = 2'b10,
        CYC_TGT   = 2'b11
    } cyc_e;

    typedef struct packed {
        logic is_long;
        logic taken;
        logic first_odd;
        logic pre;
    } br_ctx_t;

    typedef struct packed {
        cyc_e code;
        logic load;
        logic last;
    } cyc_info_t;

    // Kind of bus cycle for a given step of a captured branch.
    function automatic cyc_info_t plan_cycle(br_ctx_t c, logic [STEP_W-1:0] step);
        cyc_info_t         r;
        logic [STEP_W-1:0] body;
        logic              opc_odd;
        r.code = CYC_IDLE;
        r.load = 1'b0;
        r.last = 1'b0;
        body    = step - STEP_W'(c.pre);
        opc_odd = c.first_odd ^ c.pre;
        if (!c.is_long) begin
            if (!c.taken) begin
                if (step == '0) begin
                    r.code = CYC_FETCH;
                    r.last = 1'b1;
                end
            end else if (step < STEP_W'(3)) begin
                r.code = CYC_TGT;
                r.load = (step == '0);
                r.last = (step == STEP_W'(2));
            end
        end else if (c.pre && step == '0) begin
            r.code = c.first_odd ? CYC_FETCH : CYC_FREE;
        end else if (body == '0) begin
            r.code = opc_odd ? CYC_FREE : CYC_FETCH;
        end else if (!c.taken) begin
            if (body <= STEP_W'(2)) begin
                r.code = CYC_FETCH;
                r.last = (body == STEP_W'(2));
            end
        end else if (body <= STEP_W'(3)) begin
            r.code = CYC_TGT;
            r.load = (body == STEP_W'(1));
            r.last = (body == STEP_W'(3));
        end
        return r;
    endfunction

endpackage

// File: rtl/bcs_plan.sv
module bcs_plan
    import bcs_pkg::*;
(
    input  br_ctx_t           ctx_i,
    input  logic [STEP_W-1:0] step_i,
    output cyc_info_t         info_o
);

    always_comb begin
        info_o = plan_cycle(ctx_i, step_i);
    end

endmodule

// File: rtl/bcs_target.sv
module bcs_target #(
    parameter int ADDR_W = 16,
    parameter int SOFF_W = 8,
    parameter int LOFF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              accept_i,
    input  logic              busy_i,
    input  logic              long_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [LOFF_W-1:0] offset_i,
    output logic [ADDR_W-1:0] target_o
);

    logic [ADDR_W-1:0] short_ext;
    logic [ADDR_W-1:0] long_ext;
    logic [ADDR_W-1:0] sum;

    assign short_ext = ADDR_W'($signed(offset_i[SOFF_W-1:0]));
    assign long_ext  = ADDR_W'($signed(offset_i));
    // R12: modulo-2^ADDR_W sum
    assign sum       = next_pc_i + (long_i ? long_ext : short_ext);

    always_ff @(posedge clk) begin
        if (rst) begin
            target_o <= '0;
        end else if (accept_i) begin
            target_o <= sum;
        end
    end

    // R10
    target_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy_i && !accept_i |=> $stable(target_o));

endmodule

// File: rtl/bcs_ctl.sv
module bcs_ctl
    import bcs_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              long_i,
    input  logic              taken_i,
    input  logic              odd_i,
    input  logic              pre_i,
    input  cyc_info_t         info_i,
    output br_ctx_t           ctx_o,
    output logic [STEP_W-1:0] step_o,
    output logic              busy_o,
    output logic              accept_o,
    output logic [1:0]        cyc_o,
    output logic              load_o,
    output logic              done_o
);

    assign accept_o = start_i && !busy_o;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_o <= 1'b0;
            step_o <= '0;
            ctx_o  <= '0;
        end else if (accept_o) begin
            busy_o        <= 1'b1;
            step_o        <= '0;
            ctx_o.is_long <= long_i;
            ctx_o.taken   <= taken_i;
            ctx_o.first_odd <= odd_i;
            ctx_o.pre     <= long_i & pre_i;
        end else if (busy_o) begin
            if (info_i.last) begin
                busy_o <= 1'b0;
            end else begin
                step_o <= step_o + 1'b1;
            end
        end
    end

    assign cyc_o  = busy_o ? info_i.code : CYC_IDLE;
    assign load_o = busy_o & info_i.load;
    assign done_o = busy_o & info_i.last;

    // R9
    done_single_chk: assert property (@(posedge clk) disable iff (rst)
        done_o |=> !done_o);

    // R9
    done_then_idle_chk: assert property (@(posedge clk) disable iff (rst)
        done_o && !start_i |=> cyc_o == CYC_IDLE);

    // R4
    load_on_target_chk: assert property (@(posedge clk) disable iff (rst)
        load_o |-> cyc_o == CYC_TGT);

    // R2
    start_runs_chk: assert property (@(posedge clk) disable iff (rst)
        accept_o |=> cyc_o != CYC_IDLE);

    // R10
    ctx_frozen_chk: assert property (@(posedge clk) disable iff (rst)
        busy_o |=> $stable(ctx_o));

    // R8
    target_run_chk: assert property (@(posedge clk) disable iff (rst)
        cyc_o == CYC_TGT && !done_o |=> cyc_o == CYC_TGT);

endmodule

// File: rtl/branch_cycle_seq.sv
module branch_cycle_seq
    import bcs_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter int SOFF_W = 8,
    parameter int LOFF_W = 16
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              start_i,
    input  logic              long_i,
    input  logic              taken_i,
    input  logic              odd_i,
    input  logic              pre_i,
    input  logic [ADDR_W-1:0] next_pc_i,
    input  logic [LOFF_W-1:0] offset_i,
    output logic [1:0]        cyc_o,
    output logic              load_pc_o,
    output logic [ADDR_W-1:0] target_o,
    output logic              done_o
);

    br_ctx_t           ctx;
    logic [STEP_W-1:0] step;
    cyc_info_t         info;
    logic              busy;
    logic              accept;

    bcs_ctl ctl_i (
        .clk      (clk),
        .rst      (rst),
        .start_i  (start_i),
        .long_i   (long_i),
        .taken_i  (taken_i),
        .odd_i    (odd_i),
        .pre_i    (pre_i),
        .info_i   (info),
        .ctx_o    (ctx),
        .step_o   (step),
        .busy_o   (busy),
        .accept_o (accept),
        .cyc_o    (cyc_o),
        .load_o   (load_pc_o),
        .done_o   (done_o)
    );

    bcs_plan plan_i (
        .ctx_i  (ctx),
        .step_i (step),
        .info_o (info)
    );

    bcs_target #(
        .ADDR_W (ADDR_W),
        .SOFF_W (SOFF_W),
        .LOFF_W (LOFF_W)
    ) tgt_i (
        .clk       (clk),
        .rst       (rst),
        .accept_i  (accept),
        .busy_i    (busy),
        .long_i    (long_i),
        .next_pc_i (next_pc_i),
        .offset_i  (offset_i),
        .target_o  (target_o)
    );

endmodule

// File: tb/branch_cycle_seq_tb.sv
module branch_cycle_seq_tb_top;

    logic        clk = 1'b0;
    logic        rst;
    logic        start_i, long_i, taken_i, odd_i, pre_i;
    logic [15:0] next_pc_i, offset_i;
    logic [1:0]  cyc_o;
    logic        load_pc_o, done_o;
    logic [15:0] target_o;

    int checks = 0;
    int fails  = 0;
    bit ended  = 0;

    always #5 clk = ~clk;

    branch_cycle_seq dut_i (
        .clk(clk), .rst(rst), .start_i(start_i), .long_i(long_i),
        .taken_i(taken_i), .odd_i(odd_i), .pre_i(pre_i),
        .next_pc_i(next_pc_i), .offset_i(offset_i), .cyc_o(cyc_o),
        .load_pc_o(load_pc_o), .target_o(target_o), .done_o(done_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    // One branch: start, then compare every cycle with the computed list.
    task automatic run_case(input bit l, input bit t, input bit o, input bit p,
                            input logic [15:0] pc, input logic [15:0] off,
                            input bit meddle);
        int          exp_code[8];
        string       exp_req[8];
        int          n = 0;
        int          load_at = -1;
        logic [15:0] exp_tgt;
        bit          opc_even;
        if (!l) begin
            if (!t) begin
                exp_code[n] = 1; exp_req[n] = p ? "R11" : "R3"; n++;
            end else begin
                load_at = 0;
                for (int k = 0; k < 3; k++) begin
                    exp_code[n] = 3; exp_req[n] = p ? "R11" : "R4"; n++;
                end
            end
            exp_tgt = pc + {{8{off[7]}}, off[7:0]};
        end else begin
            if (p) begin
                exp_code[n] = o ? 1 : 2; exp_req[n] = "R5"; n++;
            end
            opc_even = ((o + p) % 2) == 0;
            exp_code[n] = opc_even ? 1 : 2; exp_req[n] = "R6"; n++;
            if (t) begin
                load_at = n;
                for (int k = 0; k < 3; k++) begin
                    exp_code[n] = 3; exp_req[n] = "R8"; n++;
                end
            end else begin
                for (int k = 0; k < 2; k++) begin
                    exp_code[n] = 1; exp_req[n] = "R7"; n++;
                end
            end
            exp_tgt = pc + off;  // R12: 16-bit wrap
        end

        @(negedge clk);
        start_i = 1; long_i = l; taken_i = t; odd_i = o; pre_i = p;
        next_pc_i = pc; offset_i = off;
        @(negedge clk);
        start_i = meddle;
        for (int i = 0; i < n; i++) begin
            if (meddle) begin
                long_i = ~l; taken_i = ~t; odd_i = ~o; pre_i = ~p;
                next_pc_i = pc ^ 16'h5A5A; offset_i = ~off;
            end
            if (i == 0) chk(cyc_o != 2'b00, "R2", cyc_o, exp_code[0]);
            chk(cyc_o == exp_code[i][1:0], meddle ? "R10" : exp_req[i], cyc_o, exp_code[i]);
            chk(done_o == (i == n - 1), "R9", done_o, (i == n - 1));
            chk(load_pc_o == (i == load_at), l ? "R8" : "R4", load_pc_o, (i == load_at));
            if (i == load_at)
                chk(target_o == exp_tgt, meddle ? "R10" : "R12", target_o, exp_tgt);
            @(negedge clk);
        end
        chk(cyc_o == 2'b00 && !done_o, meddle ? "R10" : "R9", cyc_o, 0);
        start_i = 0;
    endtask

    initial begin
        logic [15:0] pcs[3];
        logic [15:0] offs[4];
        pcs[0] = 16'h1000; pcs[1] = 16'hFFFE; pcs[2] = 16'h0002;
        offs[0] = 16'h0005; offs[1] = 16'h007F; offs[2] = 16'hFF80; offs[3] = 16'h8010;
        rst = 1; start_i = 1; long_i = 0; taken_i = 1; odd_i = 0; pre_i = 0;
        next_pc_i = 0; offset_i = 0;
        repeat (3) @(negedge clk);
        chk(cyc_o == 0 && !done_o && !load_pc_o, "R1", cyc_o, 0);
        start_i = 0;
        rst = 0;
        @(negedge clk);
        chk(cyc_o == 0 && !done_o && !load_pc_o, "R1", cyc_o, 0);
        for (int m = 0; m < 2; m++)
            for (int pi = 0; pi < 3; pi++)
                for (int oi = 0; oi < 4; oi++)
                    for (int v = 0; v < 16; v++)
                        run_case(v[3], v[2], v[1], v[0], pcs[pi], offs[oi], m[0]);
        finish_run();
    end

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

endmodule